// File: doc/BRIEF.md
# Strap Latch and Frequency Source Selector

This block sits beside a programmable clock synthesiser and decides which frequency code that synthesiser receives. After power-on reset it takes one snapshot of the configuration strap pins. These are four frequency-select straps and one output-current multiplier strap. It then holds that snapshot until the next power-on reset. The moment the snapshot is taken, the shared multiplier strap pin is handed over to its clock-output role.

A small register file, written through a simple write port and read through a read port, chooses the frequency source. In pin mode the frequency index comes from the latched straps. In register mode it comes from a 5-bit select field. The index looks up a 32-entry divider table. An override bit bypasses the table and applies a raw 16-bit divider word. Software writes that word as two bytes, and it takes effect only once both bytes have arrived. The latched straps can be read back, with the frequency-select bits inverted, through a read-only status register.

Top module: `strap_freq_sel`

## Requirements
- R1: While `rst` is high and on the cycle it falls, `pin_is_clk` is 0 and the latched straps are all 0. The control register reads 0x80 (pin mode, override off, select 0). The committed override word is 0.
- R2: The strap pins are captured on the first rising clock edge at which `rst` is low. `pin_is_clk` rises on that same edge and stays 1 until the next reset.
- R3: After capture, changes on `strap_fs` and `strap_mult` have no effect on any output or on the status register until `rst` is asserted again.
- R4: `mult_sel_6x` equals the latched multiplier strap: 0 selects 4x reference current and 1 selects 6x.
- R5: Address 3 (status, read-only) returns bits 3:0 = bitwise inverse of latched FS3..FS0 (bit n is the inverse of FSn), bit 4 = latched multiplier strap, and bits 7:5 = 0. Writes to address 3 change nothing.
- R6: Control register (address 0) bit 7 is the mode bit. When it is 1, `freq_idx` = {1'b0, latched FS3..FS0}. When it is 0, `freq_idx` = control bits 4:0.
- R7: With override off (control bit 6 = 0), `div_word` = floor((400 + 16*idx) * 102400 / 1432) for the current index `idx` in 0..31.
- R8: With control bit 6 = 1, `div_word` equals the committed override word, whatever the index.
- R9: A write to address 1 stages the low byte and a write to address 2 stages the high byte. The committed word changes only on the write that completes a pair, in either order, and is visible the cycle after that write. A single byte alone leaves it unchanged.
- R10: Reads of address 0 return the control byte (bit 5 reads 0). Reads of addresses 1 and 2 return the low and high bytes of the committed override word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| strap_fs | input | 4 | Frequency-select strap pins FS3..FS0 |
| strap_mult | input | 1 | Current-multiplier strap on the shared pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| freq_idx | output | 5 | Active frequency table index |
| div_word | output | 16 | Divider word sent to the synthesiser |
| mult_sel_6x | output | 1 | Output-current multiplier select, 1 = 6x, 0 = 4x |
| pin_is_clk | output | 1 | Shared strap pin now acts as a clock output |

## Verification
The assertions watch the properties that hold every cycle. The pin role never drops once granted, and the snapshot stays frozen after capture. The index follows the latched straps or the select field as the mode bit dictates. The override word moves only on the cycle after a divider-byte write, and the override output tracks the committed word. The bench scenarios cover the rest. They show that capture happens on the first edge and not a later one, using straps that change one cycle after reset release. They also show the inverted status encoding, the actual table values at both ends, and that a single byte does not commit while the second byte of a pair does, in both orders.

// File: rtl/freq_src_pkg.sv
`timescale 1ns/1ps
package freq_src_pkg;

    localparam int FS_W      = 4;
    localparam int IDX_W     = 5;
    localparam int ENTRIES   = 1 << IDX_W;
    localparam int DIV_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int SCALE_NUM = 102400;
    localparam int SCALE_DEN = 1432;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_DIV_LO = 2'd1,
        A_DIV_HI = 2'd2,
        A_STRAP  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             pin_mode;
        logic             ovr_en;
        logic [IDX_W-1:0] reg_sel;
    } ctrl_t;

    typedef struct packed {
        logic            mult;
        logic [FS_W-1:0] fs;
    } strap_t;

    localparam ctrl_t CTRL_RST = '{pin_mode: 1'b1, ovr_en: 1'b0, reg_sel: '0};

    function automatic logic [DIV_W-1:0] table_div(input int idx, input int base, input int step);
        int v;
        v = ((base + step * idx) * SCALE_NUM) / SCALE_DEN;
        return v[DIV_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {c.pin_mode, c.ovr_en, 1'b0, c.reg_sel};
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.pin_mode = b[7];
        c.ovr_en   = b[6];
        c.reg_sel  = b[IDX_W-1:0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] strap_to_byte(input strap_t s);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[FS_W-1:0] = ~s.fs;
        b[FS_W]     = s.mult;
        return b;
    endfunction

endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture
    import freq_src_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [FS_W-1:0] fs_pin,
    input  logic            mult_pin,
    output strap_t          latched,
    output logic            captured
);

    always_ff @(posedge clk) begin
        if (rst) begin
            latched  <= '0;
            captured <= 1'b0;
        end else if (!captured) begin
            latched  <= '{mult: mult_pin, fs: fs_pin};
            captured <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
module cfg_regs
    import freq_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  ovr_word
);

    logic [BYTE_W-1:0] stage_lo, stage_hi;
    logic [BYTE_W-1:0] lo_next, hi_next;
    logic              lo_seen, hi_seen;
    logic              lo_hit, hi_hit, ctrl_hit, pair_done;

    always_comb begin
        ctrl_hit  = wr_en && (wr_addr == A_CTRL);
        lo_hit    = wr_en && (wr_addr == A_DIV_LO);
        hi_hit    = wr_en && (wr_addr == A_DIV_HI);
        lo_next   = lo_hit ? wr_data : stage_lo;
        hi_next   = hi_hit ? wr_data : stage_hi;
        pair_done = (lo_seen || lo_hit) && (hi_seen || hi_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= CTRL_RST;
            stage_lo <= '0;
            stage_hi <= '0;
            lo_seen  <= 1'b0;
            hi_seen  <= 1'b0;
            ovr_word <= '0;
        end else begin
            if (ctrl_hit) begin
                ctrl <= byte_to_ctrl(wr_data);
            end
            stage_lo <= lo_next;
            stage_hi <= hi_next;
            if (pair_done) begin
                ovr_word <= {hi_next, lo_next};
                lo_seen  <= 1'b0;
                hi_seen  <= 1'b0;
            end else begin
                lo_seen  <= lo_seen || lo_hit;
                hi_seen  <= hi_seen || hi_hit;
            end
        end
    end

endmodule

// File: rtl/freq_mux.sv
`timescale 1ns/1ps
module freq_mux
    import freq_src_pkg::*;
#(
    parameter int VCO_BASE = 400,
    parameter int VCO_STEP = 16
) (
    input  ctrl_t            ctrl,
    input  strap_t           latched,
    input  logic [DIV_W-1:0] ovr_word,
    output logic [IDX_W-1:0] freq_idx,
    output logic [DIV_W-1:0] div_word
);

    localparam int PAD_W = IDX_W - FS_W;

    logic [DIV_W-1:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_tbl
        assign tbl[g] = table_div(g, VCO_BASE, VCO_STEP);
    end

    always_comb begin
        freq_idx = ctrl.pin_mode ? {{PAD_W{1'b0}}, latched.fs} : ctrl.reg_sel;
        div_word = ctrl.ovr_en ? ovr_word : tbl[freq_idx];
    end

endmodule

// File: rtl/strap_freq_sel.sv
`timescale 1ns/1ps
module strap_freq_sel
    import freq_src_pkg::*;
#(
    parameter int VCO_BASE = 400,
    parameter int VCO_STEP = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FS_W-1:0]   strap_fs,
    input  logic              strap_mult,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  freq_idx,
    output logic [DIV_W-1:0]  div_word,
    output logic              mult_sel_6x,
    output logic              pin_is_clk
);

    strap_t           latched_s;
    ctrl_t            ctrl_s;
    logic [DIV_W-1:0] ovr_word_s;

    strap_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .fs_pin   (strap_fs),
        .mult_pin (strap_mult),
        .latched  (latched_s),
        .captured (pin_is_clk)
    );

    cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl_s),
        .ovr_word (ovr_word_s)
    );

    freq_mux #(
        .VCO_BASE (VCO_BASE),
        .VCO_STEP (VCO_STEP)
    ) u_mux (
        .ctrl     (ctrl_s),
        .latched  (latched_s),
        .ovr_word (ovr_word_s),
        .freq_idx (freq_idx),
        .div_word (div_word)
    );

    assign mult_sel_6x = latched_s.mult;

    always_comb begin
        unique case (rd_addr)
            A_CTRL:   rd_data = ctrl_to_byte(ctrl_s);
            A_DIV_LO: rd_data = ovr_word_s[BYTE_W-1:0];
            A_DIV_HI: rd_data = ovr_word_s[DIV_W-1:BYTE_W];
            default:  rd_data = strap_to_byte(latched_s);
        endcase
    end

endmodule

// File: rtl/strap_freq_sel_chk.sv
`timescale 1ns/1ps
module strap_freq_sel_chk
    import freq_src_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              pin_is_clk,
    input logic              mult_sel_6x,
    input logic [IDX_W-1:0]  freq_idx,
    input logic [DIV_W-1:0]  div_word,
    input ctrl_t             ctrl_s,
    input strap_t            latched_s,
    input logic [DIV_W-1:0]  ovr_word_s
);

    AST_RESET_CTRL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_s.pin_mode && !ctrl_s.ovr_en && ovr_word_s == '0)); // R1

    AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        pin_is_clk |=> pin_is_clk); // R2

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        pin_is_clk |=> ($stable(latched_s) && $stable(mult_sel_6x))); // R3

    AST_PIN_INDEX: assert property (@(posedge clk) disable iff (rst)
        ctrl_s.pin_mode |-> (freq_idx == {{(IDX_W-FS_W){1'b0}}, latched_s.fs})); // R6

    AST_REG_INDEX: assert property (@(posedge clk) disable iff (rst)
        !ctrl_s.pin_mode |-> (freq_idx == ctrl_s.reg_sel)); // R6

    AST_OVR_SELECT: assert property (@(posedge clk) disable iff (rst)
        ctrl_s.ovr_en |-> (div_word == ovr_word_s)); // R8

    AST_WORD_ATOMIC: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en && (wr_addr == A_DIV_LO || wr_addr == A_DIV_HI)) |-> $stable(ovr_word_s)); // R9

endmodule

bind strap_freq_sel strap_freq_sel_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .pin_is_clk  (pin_is_clk),
    .mult_sel_6x (mult_sel_6x),
    .freq_idx    (freq_idx),
    .div_word    (div_word),
    .ctrl_s      (ctrl_s),
    .latched_s   (latched_s),
    .ovr_word_s  (ovr_word_s)
);

// File: tb/strap_freq_sel_tb_top.sv
`timescale 1ns/1ps
module strap_freq_sel_tb_top;

    typedef enum int { K_IDX, K_DIV, K_MULT, K_ROLE, K_RD } kind_e;

    typedef struct {
        kind_e   kind;
        int      exp;
        string   req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] strap_fs = '0;
    logic       strap_mult = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [4:0] freq_idx;
    logic [15:0] div_word;
    logic       mult_sel_6x;
    logic       pin_is_clk;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    item_t sb_q[$];

    always #4 clk = ~clk;

    strap_freq_sel dut_i (
        .clk         (clk),
        .rst         (rst),
        .strap_fs    (strap_fs),
        .strap_mult  (strap_mult),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .freq_idx    (freq_idx),
        .div_word    (div_word),
        .mult_sel_6x (mult_sel_6x),
        .pin_is_clk  (pin_is_clk)
    );

    function automatic int tbl_div(input int i);
        return ((400 + 16 * i) * 102400) / 1432;
    endfunction

    // driver side: one expectation per call, one cycle each
    task automatic expect_item(input kind_e k, input logic [1:0] a, input int e, input string r);
        item_t it;
        @(negedge clk);
        rd_addr = a;
        #1;
        it.kind = k; it.exp = e; it.req = r;
        sb_q.push_back(it);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor side: pops and compares before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_IDX:   act = int'(freq_idx);
                    K_DIV:   act = int'(div_word);
                    K_MULT:  act = int'(mult_sel_6x);
                    K_ROLE:  act = int'(pin_is_clk);
                    default: act = int'(rd_data);
                endcase
                n_run++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%s actual=0x%0h expected=0x%0h",
                             it.req, it.kind.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state, straps already present on the pins
        strap_fs = 4'b1010; strap_mult = 1'b1;
        expect_item(K_ROLE, 2'd0, 0, "R1");
        expect_item(K_RD,   2'd0, 8'h80, "R1");
        expect_item(K_RD,   2'd3, 8'h0F, "R1");
        expect_item(K_IDX,  2'd0, 0, "R1");
        expect_item(K_RD,   2'd1, 0, "R1");

        // R2 release reset, change straps one cycle later
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        strap_fs = 4'b0101; strap_mult = 1'b0;
        expect_item(K_ROLE, 2'd0, 1, "R2");
        expect_item(K_IDX,  2'd0, 10, "R2");
        expect_item(K_MULT, 2'd0, 1, "R4");
        expect_item(K_RD,   2'd3, 8'h15, "R5");
        expect_item(K_DIV,  2'd0, tbl_div(10), "R7");

        // R3 later strap activity is ignored
        strap_fs = 4'b1111; strap_mult = 1'b0;
        repeat (3) @(negedge clk);
        expect_item(K_IDX,  2'd0, 10, "R3");
        expect_item(K_RD,   2'd3, 8'h15, "R3");
        expect_item(K_MULT, 2'd0, 1, "R3");

        // R5 status register is read-only
        reg_write(2'd3, 8'hFF);
        expect_item(K_RD, 2'd3, 8'h15, "R5");
        expect_item(K_RD, 2'd0, 8'h80, "R5");

        // R6/R7 register-select mode across the table
        reg_write(2'd0, 8'h17);
        expect_item(K_IDX, 2'd0, 23, "R6");
        expect_item(K_DIV, 2'd0, tbl_div(23), "R7");
        expect_item(K_RD,  2'd0, 8'h17, "R10");
        reg_write(2'd0, 8'h1F);
        expect_item(K_DIV, 2'd0, tbl_div(31), "R7");
        reg_write(2'd0, 8'h00);
        expect_item(K_DIV, 2'd0, tbl_div(0), "R7");

        // R9 low then high, override on between them
        reg_write(2'd1, 8'h34);
        reg_write(2'd0, 8'h40);
        expect_item(K_DIV, 2'd0, 0, "R9");
        expect_item(K_RD,  2'd1, 0, "R10");
        reg_write(2'd2, 8'h12);
        expect_item(K_DIV, 2'd0, 16'h1234, "R9");
        expect_item(K_RD,  2'd1, 8'h34, "R10");
        expect_item(K_RD,  2'd2, 8'h12, "R10");

        // R9 high then low
        reg_write(2'd2, 8'hAB);
        expect_item(K_DIV, 2'd0, 16'h1234, "R9");
        reg_write(2'd1, 8'hCD);
        expect_item(K_DIV, 2'd0, 16'hABCD, "R9");

        // R8 override wins over a changed select field
        reg_write(2'd0, 8'h45);
        expect_item(K_IDX, 2'd0, 5, "R8");
        expect_item(K_DIV, 2'd0, 16'hABCD, "R8");

        // R6 back to pin mode, override off
        reg_write(2'd0, 8'h80);
        expect_item(K_IDX, 2'd0, 10, "R6");
        expect_item(K_DIV, 2'd0, tbl_div(10), "R6");

        // R1/R4 second power-on reset with the 4x multiplier strap
        @(negedge clk);
        rst = 1'b1;
        strap_fs = 4'b0000; strap_mult = 1'b0;
        expect_item(K_ROLE, 2'd0, 0, "R1");
        expect_item(K_RD,   2'd0, 8'h80, "R1");
        expect_item(K_RD,   2'd2, 0, "R1");
        @(negedge clk);
        rst = 1'b0;
        expect_item(K_ROLE, 2'd0, 1, "R2");
        expect_item(K_MULT, 2'd0, 0, "R4");
        expect_item(K_RD,   2'd3, 8'h0F, "R5");
        expect_item(K_DIV,  2'd0, tbl_div(0), "R7");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule